// File: doc/BRIEF.md
# Serial Latched-Driver Chain Loader

This block loads a parallel frame into a cascade of serial-input latched output drivers. The host offers one frame of `WORD_W * N_DEV` bits with a valid/ready handshake. The block then moves the bits into the chain one at a time on a generated shift clock, with the most significant bit first. After the last bit it waits a fixed interval, pulses the transfer strobe, and reports completion with a one-cycle `done` pulse.

Every timing rule of the driven chain is given in nanoseconds as a parameter and rounded up to a whole number of system-clock cycles. These rules are data setup and data hold around each rising shift edge, the minimum shift-clock high time, the minimum shift-clock period, the spacing from the last shift edge to the strobe, and the strobe width. Changing the clock-period parameter or the shift-period parameter re-derives every phase length, so the same block can run the chain anywhere from a slow rate up to its fastest allowed rate.

A build-time option serves boards whose strobe pin is tied high, so the latches are transparent. In that mode the strobe output is held high, and blanking is forced on for the whole load so that the shifting bits never reach the outputs. Outside that mode, blanking simply follows the host's request.

Top module: `serial_latch_loader`

## Requirements
- R1: While reset is held, and right after it is released, `sclk` and `done` are low, `frame_ready` is high and `busy` is low. `strobe` is low in normal mode and high in tied mode. `blank` equals `blank_req` in normal mode.
- R2: A frame is taken only on a cycle where `frame_valid` and `frame_ready` are both high. `frame_ready` is low for the whole time `busy` is high, and frames offered during that time are ignored: they change neither the load in progress nor the latched result.
- R3: Each frame produces exactly `WORD_W*N_DEV` rising edges of `sclk`, with `frame_data` sent from the highest index down. When the chain is modelled as stages numbered from 0 at its input, each rising edge moves the value in stage k into stage k+1 and takes `sdata` into stage 0. After a load, stage k holds `frame_data[k]`.
- R4: `sdata` is stable for at least ceil(SU_NS/CLK_NS) cycles before each rising edge of `sclk`.
- R5: `sdata` stays stable for at least ceil(HD_NS/CLK_NS) cycles after each rising edge of `sclk`, and it never changes while `sclk` is high.
- R6: Every high pulse of `sclk` lasts at least ceil(CKH_NS/CLK_NS) cycles. Successive rising edges are at least ceil(SCLK_NS/CLK_NS) cycles apart.
- R7: In normal mode `strobe` is never high while the chain is being shifted. Its rising edge comes at least ceil(GAP_NS/CLK_NS) cycles after the last rising edge of `sclk`.
- R8: In normal mode each frame gives exactly one `strobe` pulse, at least ceil(STB_NS/CLK_NS) cycles wide.
- R9: `busy` rises in the cycle after acceptance and stays high until `strobe` falls. In that same cycle `done` is high for exactly one cycle and `busy` is already low.
- R10: In tied mode (`TIED=1`), `strobe` is always high and `blank` is high whenever `busy` or `blank_req` is high. Because the latches are transparent in this mode, the latched result still equals the frame after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Host offers a frame |
| frame_data | input | WORD_W*N_DEV | Frame; bit k ends in chain stage k |
| frame_ready | output | 1 | Block is idle and will take a frame |
| busy | output | 1 | Load in progress, from acceptance to the end of the strobe |
| done | output | 1 | One-cycle pulse when a load finishes |
| blank_req | input | 1 | Host request to blank the driver outputs |
| sdata | output | 1 | Serial data to the chain |
| sclk | output | 1 | Shift clock to the chain |
| strobe | output | 1 | Latch transfer strobe |
| blank | output | 1 | Output blanking to the chain |

## Verification
The bound checker watches four things on every cycle: the minimum `sclk` high width, that `sdata` holds still while `sclk` is high, the strobe width, and that strobe and shift clock are never high together. It also checks the relation between `busy`, `done` and the end of the strobe.

Only the bench's chain model can show the rest. That covers the bit order and the latched result, the number of shift edges, setup measured back from each rising edge, the shift period and the last-edge-to-strobe spacing, and the fact that frames offered while busy leave the result unchanged. The bench does this by sweeping every 8-bit frame through a normal-mode instance and a tied-mode instance that run in lockstep.

// File: rtl/serial_latch_loader.sv
module serial_latch_loader #(
  parameter int WORD_W  = 32,
  parameter int N_DEV   = 1,
  parameter int CLK_NS  = 10,
  parameter int SCLK_NS = 100,
  parameter int SU_NS   = 25,
  parameter int HD_NS   = 25,
  parameter int CKH_NS  = 50,
  parameter int GAP_NS  = 100,
  parameter int STB_NS  = 50,
  parameter bit TIED    = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_valid,
  input  logic [WORD_W*N_DEV-1:0]   frame_data,
  output logic                      frame_ready,
  output logic                      busy,
  output logic                      done,
  input  logic                      blank_req,
  output logic                      sdata,
  output logic                      sclk,
  output logic                      strobe,
  output logic                      blank
);

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int TOT    = WORD_W * N_DEV;
  localparam int C_SU   = cdiv(SU_NS, CLK_NS);
  localparam int C_HD   = cdiv(HD_NS, CLK_NS);
  localparam int C_CKH  = cdiv(CKH_NS, CLK_NS);
  localparam int C_PER  = cdiv(SCLK_NS, CLK_NS);
  localparam int C_HALF = (C_PER + 1) / 2;
  localparam int C_GAP  = cdiv(GAP_NS, CLK_NS);
  localparam int C_STB  = cdiv(STB_NS, CLK_NS);

  localparam int HI_A   = (C_CKH > C_HD) ? C_CKH : C_HD;
  localparam int HI_B   = (HI_A > C_HALF) ? HI_A : C_HALF;
  localparam int N_HI   = (HI_B < 1) ? 1 : HI_B;
  localparam int LO_A   = (C_SU > C_PER - N_HI) ? C_SU : C_PER - N_HI;
  localparam int N_LO   = (LO_A < 1) ? 1 : LO_A;
  localparam int N_WAIT = (C_GAP > N_HI) ? C_GAP - N_HI : 1;
  localparam int N_STB  = (C_STB < 1) ? 1 : C_STB;

  localparam int M_A    = (N_LO > N_HI) ? N_LO : N_HI;
  localparam int M_B    = (N_WAIT > N_STB) ? N_WAIT : N_STB;
  localparam int CMAX   = (M_A > M_B) ? M_A : M_B;
  localparam int CW     = $clog2(CMAX + 1);
  localparam int BW     = $clog2(TOT + 1);

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_WAIT, S_STB} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bits_left;
  logic [TOT-1:0]  shreg;

  wire last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      shreg     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (frame_valid) begin
          st        <= S_LO;
          cnt       <= CW'(N_LO - 1);
          shreg     <= frame_data;
          bits_left <= BW'(TOT - 1);
        end
        S_LO: if (last) begin
          st  <= S_HI;
          cnt <= CW'(N_HI - 1);
        end else cnt <= cnt - 1'b1;
        S_HI: if (last) begin
          if (bits_left == '0) begin
            st  <= S_WAIT;
            cnt <= CW'(N_WAIT - 1);
          end else begin
            st        <= S_LO;
            cnt       <= CW'(N_LO - 1);
            shreg     <= {shreg[TOT-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (last) begin
          st  <= S_STB;
          cnt <= CW'(N_STB - 1);
        end else cnt <= cnt - 1'b1;
        S_STB: if (last) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign frame_ready = (st == S_IDLE);
  assign busy        = ~frame_ready;
  assign sclk        = (st == S_HI);
  assign sdata       = shreg[TOT-1];
  assign strobe      = TIED ? 1'b1 : (st == S_STB);
  assign blank       = blank_req | (TIED & busy);

endmodule

// File: rtl/loader_chk.sv
module loader_chk #(
  parameter int CLK_NS = 10,
  parameter int HD_NS  = 25,
  parameter int CKH_NS = 50,
  parameter int STB_NS = 50,
  parameter bit TIED   = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic frame_valid,
  input logic frame_ready,
  input logic busy,
  input logic done,
  input logic sdata,
  input logic sclk,
  input logic strobe
);

  localparam int M_CKH  = (CKH_NS + CLK_NS - 1) / CLK_NS;
  localparam int M_HD   = (HD_NS + CLK_NS - 1) / CLK_NS;
  localparam int MIN_HI = (M_CKH > M_HD) ? M_CKH : M_HD;
  localparam int MIN_ST = (STB_NS + CLK_NS - 1) / CLK_NS;

  logic [15:0] hi_run, stb_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      stb_run <= '0;
    end else begin
      hi_run  <= sclk   ? ((hi_run  == 16'hFFFF) ? hi_run  : hi_run  + 1'b1) : '0;
      stb_run <= strobe ? ((stb_run == 16'hFFFF) ? stb_run : stb_run + 1'b1) : '0;
    end
  end

  // R6
  sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_run >= 16'(MIN_HI));

  // R5
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!TIED && $fell(strobe)) |-> stb_run >= 16'(MIN_ST));

  // R7
  strobe_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !TIED |-> !(sclk && strobe));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_ready) |=> busy);

  // R9
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !TIED) |-> (!busy && $past(strobe)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind serial_latch_loader loader_chk #(
  .CLK_NS(CLK_NS), .HD_NS(HD_NS), .CKH_NS(CKH_NS), .STB_NS(STB_NS), .TIED(TIED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
  .busy(busy), .done(done), .sdata(sdata), .sclk(sclk), .strobe(strobe)
);

// File: tb/tb_serial_latch_loader.sv
module tb_serial_latch_loader;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4, ND = 2, TOT = W * ND;
  localparam int P = 10, SCLK = 100, SU = 25, HD = 25, CKH = 50, GAP = 100, STB = 50;
  localparam int E_SU  = (SU + P - 1) / P;
  localparam int E_HD  = (HD + P - 1) / P;
  localparam int E_HI  = (CKH + P - 1) / P;
  localparam int E_PER = (SCLK + P - 1) / P;
  localparam int E_GAP = (GAP + P - 1) / P;
  localparam int E_STB = (STB + P - 1) / P;

  logic clk = 0, rst_n = 0, fv = 0, br = 0;
  logic [TOT-1:0] fd = '0;
  logic ready, busy, done, sdata, sclk, strobe, blank;
  logic t_ready, t_busy, t_done, t_sdata, t_sclk, t_strobe, t_blank;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_loader #(.WORD_W(W), .N_DEV(ND), .CLK_NS(P), .SCLK_NS(SCLK), .SU_NS(SU),
    .HD_NS(HD), .CKH_NS(CKH), .GAP_NS(GAP), .STB_NS(STB), .TIED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(fv), .frame_data(fd), .frame_ready(ready),
    .busy(busy), .done(done), .blank_req(br), .sdata(sdata), .sclk(sclk),
    .strobe(strobe), .blank(blank));

  serial_latch_loader #(.WORD_W(W), .N_DEV(ND), .CLK_NS(P), .SCLK_NS(SCLK), .SU_NS(SU),
    .HD_NS(HD), .CKH_NS(CKH), .GAP_NS(GAP), .STB_NS(STB), .TIED(1'b1)) dut_tied (
    .clk(clk), .rst_n(rst_n), .frame_valid(fv), .frame_data(fd), .frame_ready(t_ready),
    .busy(t_busy), .done(t_done), .blank_req(br), .sdata(t_sdata), .sclk(t_sclk),
    .strobe(t_strobe), .blank(t_blank));

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // chain model and interval measurement
  logic [TOT-1:0] chain = '0, latch = '0, t_chain = '0, t_latch = '0;
  logic p_sclk = 0, p_sdata = 0, p_strobe = 0, p_tsclk = 0;
  int cyc = 0, last_chg = 0, last_rise = -1000, prev_rise = -1000, stb_rise = 0, stb_fall = -1;
  int rises, pulses, min_su, min_hd, min_hi, min_per, gap, stb_w, v_shift, v_blank, v_tied;

  task automatic clear_stats();
    rises = 0; pulses = 0; min_su = 1 << 20; min_hd = 1 << 20; min_hi = 1 << 20;
    min_per = 1 << 20; gap = -1; stb_w = -1; v_shift = 0; v_blank = 0; v_tied = 0;
    prev_rise = -1000;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sdata != p_sdata) begin
        last_chg = cyc;
        if (cyc - last_rise < min_hd) min_hd = cyc - last_rise;
      end
      if (sclk && !p_sclk) begin
        rises++;
        if (cyc - last_chg < min_su) min_su = cyc - last_chg;
        if (cyc - prev_rise < min_per) min_per = cyc - prev_rise;
        prev_rise = cyc;
        last_rise = cyc;
        chain = {chain[TOT-2:0], sdata};
      end
      if (!sclk && p_sclk && (cyc - last_rise < min_hi)) min_hi = cyc - last_rise;
      if (strobe) latch = chain;
      if (strobe && !p_strobe) begin pulses++; stb_rise = cyc; gap = cyc - last_rise; end
      if (!strobe && p_strobe) begin stb_w = cyc - stb_rise; stb_fall = cyc; end
      if (strobe && sclk) v_shift++;
      if (blank != br) v_blank++;
      if (t_sclk && !p_tsclk) t_chain = {t_chain[TOT-2:0], t_sdata};
      if (t_strobe) t_latch = t_chain;
      if (!t_strobe || (t_blank != (br | t_busy))) v_tied++;
    end
    p_sclk = sclk; p_sdata = sdata; p_strobe = strobe; p_tsclk = t_sclk;
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send(input logic [TOT-1:0] data, input bit offer_busy);
    int wait_n;
    while (!ready) @(negedge clk);
    clear_stats();
    fv = 1; fd = data;
    @(negedge clk); #1;
    fv = 0;
    check("R2 busy after accept", busy === 1'b1, busy, 1);
    check("R9 busy held", t_busy === 1'b1 && ready === 1'b0, busy, 1);
    if (offer_busy) begin
      repeat (3) @(negedge clk);
      fv = 1; fd = ~data;
      repeat (4) begin
        @(negedge clk); #1;
        check("R2 ready low while busy", ready === 1'b0, ready, 0);
      end
      fv = 0;
    end
    wait_n = 0;
    while (done !== 1'b1 && wait_n < 2000) begin @(negedge clk); #1; wait_n++; end
    check("R9 done reached", wait_n < 2000, wait_n, 0);
    check("R9 busy low at done", busy === 1'b0, busy, 0);
    check("R9 done with strobe fall", stb_fall == cyc, stb_fall, cyc);
    check("R3 latched frame", latch == data, latch, data);
    check("R3 shift edge count", rises == TOT, rises, TOT);
    check("R4 setup cycles", min_su >= E_SU, min_su, E_SU);
    check("R5 hold cycles", min_hd >= E_HD, min_hd, E_HD);
    check("R6 high width", min_hi >= E_HI, min_hi, E_HI);
    check("R6 shift period", min_per >= E_PER, min_per, E_PER);
    check("R7 strobe gap", gap >= E_GAP, gap, E_GAP);
    check("R7 no strobe during shift", v_shift == 0, v_shift, 0);
    check("R8 single strobe", pulses == 1, pulses, 1);
    check("R8 strobe width", stb_w >= E_STB, stb_w, E_STB);
    check("R10 normal blank follows request", v_blank == 0, v_blank, 0);
    check("R10 tied strobe and blank", v_tied == 0, v_tied, 0);
    check("R10 tied latched frame", t_latch == data, t_latch, data);
    @(negedge clk); #1;
    check("R9 done one cycle", done === 1'b0, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 reset outputs", sclk === 0 && strobe === 0 && blank === 0 && done === 0,
          {sclk, strobe, blank, done}, 0);
    check("R1 reset handshake", ready === 1 && busy === 0, {ready, busy}, 2);
    check("R1 tied strobe high", t_strobe === 1'b1, t_strobe, 1);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 after release", sclk === 0 && strobe === 0 && ready === 1 && busy === 0,
          {sclk, strobe, ready, busy}, 2);
    for (int d = 0; d < (1 << TOT); d++) begin
      br = (d % 7 == 3);
      send(TOT'(d), (d % 16 == 5));
    end
    br = 1;
    send(8'hA5, 1'b1);
    send(8'h5A, 1'b0);
    report();
  end
endmodule